// File: doc/BRIEF.md
# Two-wire timekeeper register slave

This block is a two-wire (I2C) bus slave that answers at 7-bit address 1101000. Through an auto-incrementing word pointer, it gives a host access to a bank of eight byte registers. Indexes 0 to 6 hold the user-visible copy of the calendar and time counters. Index 7 holds a calibration byte in plain binary. The block samples SDA and SCL with the system clock and detects START, repeated START and STOP. It acknowledges its address, the word-address byte and every written byte, and it shifts read bytes out MSB first. SDA is driven as an open-drain enable: when `sda_oe_o` is 1, the pad pulls the line low.

The timekeeping logic outside the block offers a fresh snapshot of counters 0 to 6 on a valid/ready stream (`live_valid_i`, `live_time_i`, `live_ready_o`). A beat transfers on any cycle where valid and ready are both high, and all seven bytes load together. The producer must hold `live_time_i` stable while valid is high and ready is low. It may also drop valid and present a newer snapshot later, because only the most recent value matters. Ready goes low while an addressed transfer has the pointer on a clock index, so the host never sees the counters change partway through a read. Ready returns on STOP or when the pointer reaches index 7.

Writing a data byte to a clock index raises a one-cycle divider-reset pulse. The written values are visible to the timekeeping logic on `time_o` and `cal_o`. A power-fail input aborts any transfer and clears the pointer, and the bus is ignored for as long as the input is held.

Top module: `tk_i2c_regs`

## Requirements
- R1: The address byte 0xD0 (write) or 0xD1 (read) is acknowledged by driving SDA low during the ninth clock. Any other address byte is not acknowledged, and the rest of that transfer is ignored, leaving every register unchanged.
- R2: In a write transfer, the first byte after the address loads the pointer from its low 3 bits. Each later byte is stored at the pointer, and the pointer then advances by one on that byte's acknowledge clock.
- R3: A read after a repeated START returns the byte at the pointer, MSB first, with SDA driven low only for 0 bits. The pointer advances by one on each acknowledge clock in which the master drives SDA low, and the following byte comes from the new pointer.
- R4: A read with no preceding pointer write starts at the retained pointer. An acknowledge clock with SDA high (NACK) leaves the pointer unchanged, and after it the slave releases SDA.
- R5: The pointer advances from 7 to 0, for both writes and reads.
- R6: Index 7 (`cal_o`) changes only by a host write to index 7. A snapshot transfer never alters it.
- R7: `div_rst_o` pulses high for exactly one cycle for every data byte written to indexes 0 to 6. A byte written to index 7 raises no pulse.
- R8: `live_ready_o` is low while an addressed transfer is open and the pointer is 0 to 6, and high otherwise, including after STOP and once the pointer reaches 7. A transfer of a snapshot loads indexes 0 to 6 from `live_time_i` (byte k from bits 8k+7:8k), and while ready is low the user copy holds.
- R9: While `pwr_fail_i` is high, SDA is released from the next cycle, the pointer is 0, and all bus activity, including a full write transfer, is ignored.
- R10: After reset, all registers are 0, the pointer is 0, SDA is released and `live_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| pwr_fail_i | input | 1 | Supply out of tolerance; aborts and blocks access |
| live_valid_i | input | 1 | Snapshot of counters offered |
| live_ready_o | output | 1 | Snapshot may be loaded this cycle |
| live_time_i | input | 56 | Snapshot, byte k in bits 8k+7:8k |
| time_o | output | 56 | User copy of indexes 0 to 6 |
| cal_o | output | 8 | Calibration byte, index 7 |
| div_rst_o | output | 1 | One-cycle pulse after a write to a clock index |

## Verification
The bench reads back over the bus after a NACK, which catches a pointer that advances on a NACK: that read would return the following byte. A write starting at index 7 checks the wrap to index 0 and shows that the calibration write raises no divider pulse. A design that wrapped wrongly would store the second byte elsewhere or pulse twice. A snapshot offered while the pointer sits on a clock index must wait until STOP, and ready must return once a write moves the pointer to 7. A leaky freeze shows up as a changed `time_o` in mid-transfer. Power-fail is raised while the slave is driving a 0 bit, then a complete write is sent. A design that kept its state would keep SDA low, acknowledge the write or read back from a stale pointer.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int unsigned TK_BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WORD,
    ST_WACK,
    ST_DATA,
    ST_DACK,
    ST_RD,
    ST_RACK
  } tk_state_e;
endpackage

// File: rtl/tk_sync.sv
module tk_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '1;
      hold_q <= '1;
    end else begin
      meta_q <= d_i;
      hold_q <= meta_q;
    end
  end

  assign q_o = hold_q;
endmodule

// File: rtl/tk_bus_cond.sv
module tk_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  // data edges while the clock stays high are bus conditions
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tk_regfile.sv
module tk_regfile #(
  parameter int unsigned CLK_REGS = 7,
  parameter int unsigned PW       = 3,
  parameter int unsigned DW       = 8,
  localparam int unsigned NUM     = CLK_REGS + 1,
  localparam int unsigned TW      = CLK_REGS * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          cp_en,
  input  logic [TW-1:0] cp_data,
  input  logic [PW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [TW-1:0] time_o,
  output logic [DW-1:0] cal_o
);
  logic [NUM-1:0][DW-1:0] rv;

  for (genvar i = 0; i < NUM; i++) begin : g_reg
    logic [DW-1:0] r_q;
    if (i < CLK_REGS) begin : g_clk
      // host write wins over a snapshot load of the same byte
      always_ff @(posedge clk) begin
        if (!rst_n)                             r_q <= '0;
        else if (wr_en && wr_addr == PW'(i))    r_q <= wr_data;
        else if (cp_en)                         r_q <= cp_data[i*DW +: DW];
      end
      assign time_o[i*DW +: DW] = r_q;
    end else begin : g_cal
      always_ff @(posedge clk) begin
        if (!rst_n)                             r_q <= '0;
        else if (wr_en && wr_addr == PW'(i))    r_q <= wr_data;
      end
      assign cal_o = r_q;
    end
    assign rv[i] = r_q;
  end

  assign rd_data = rv[rd_addr];
endmodule

// File: rtl/tk_bus_fsm.sv
module tk_bus_fsm
  import tk_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h68,
  parameter int unsigned CLK_REGS = 7,
  parameter int unsigned PW       = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pf,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_c,
  input  logic                 stop_c,
  input  logic                 sda_in,
  input  logic [TK_BYTE_W-1:0] rd_byte,
  output logic                 sda_oe,
  output logic [PW-1:0]        ptr_o,
  output logic                 in_xfer_o,
  output logic                 wr_stb_o,
  output logic [TK_BYTE_W-1:0] wr_data_o,
  output logic                 div_rst_o
);
  localparam logic [3:0]    BITS    = 4'(TK_BYTE_W);
  localparam logic [3:0]    LAST_B  = 4'(TK_BYTE_W - 1);
  localparam logic [PW-1:0] LAST_IX = PW'(CLK_REGS);
  localparam logic [PW-1:0] CLK_LIM = PW'(CLK_REGS);

  tk_state_e            st_q;
  logic [3:0]           cnt_q;
  logic [TK_BYTE_W-1:0] sh_q;
  logic [PW-1:0]        ptr_q, ptr_nx;
  logic                 rw_q, xfer_q, mack_q, div_q;

  assign ptr_nx    = (ptr_q == LAST_IX) ? '0 : ptr_q + PW'(1);
  assign wr_stb_o  = !pf && (st_q == ST_DACK) && scl_rise;
  assign wr_data_o = sh_q;
  assign ptr_o     = ptr_q;
  assign in_xfer_o = xfer_q;
  assign div_rst_o = div_q;
  assign sda_oe    = !pf && ((st_q == ST_AACK) || (st_q == ST_WACK) ||
                             (st_q == ST_DACK) || (st_q == ST_RD && !sh_q[7]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      ptr_q  <= '0;
      rw_q   <= 1'b0;
      xfer_q <= 1'b0;
      mack_q <= 1'b0;
      div_q  <= 1'b0;
    end else begin
      div_q <= wr_stb_o && (ptr_q < CLK_LIM);
      if (pf) begin
        st_q   <= ST_IDLE;
        ptr_q  <= '0;
        xfer_q <= 1'b0;
        cnt_q  <= '0;
      end else if (start_c) begin
        st_q  <= ST_ADDR;
        cnt_q <= '0;
      end else if (stop_c) begin
        st_q   <= ST_IDLE;
        xfer_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_WORD, ST_DATA: begin
            if (scl_rise && cnt_q != BITS) begin
              sh_q  <= {sh_q[TK_BYTE_W-2:0], sda_in};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall && cnt_q == BITS) begin
              cnt_q <= '0;
              if (st_q == ST_ADDR) begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  rw_q   <= sh_q[0];
                  xfer_q <= 1'b1;
                  st_q   <= ST_AACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else if (st_q == ST_WORD) begin
                ptr_q <= sh_q[PW-1:0];
                st_q  <= ST_WACK;
              end else begin
                st_q <= ST_DACK;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            if (rw_q) begin
              st_q <= ST_RD;
              sh_q <= rd_byte;
            end else begin
              st_q <= ST_WORD;
            end
          end
          ST_WACK: if (scl_fall) st_q <= ST_DATA;
          ST_DACK: begin
            if (scl_rise) ptr_q <= ptr_nx;
            if (scl_fall) st_q <= ST_DATA;
          end
          ST_RD: if (scl_fall) begin
            if (cnt_q == LAST_B) begin
              st_q  <= ST_RACK;
              cnt_q <= '0;
            end else begin
              sh_q  <= {sh_q[TK_BYTE_W-2:0], 1'b0};
              cnt_q <= cnt_q + 4'd1;
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack_q <= !sda_in;
              if (!sda_in) ptr_q <= ptr_nx;
            end
            if (scl_fall) begin
              if (mack_q) begin
                st_q <= ST_RD;
                sh_q <= rd_byte;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tk_i2c_regs.sv
module tk_i2c_regs
  import tk_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h68,
  parameter int unsigned CLK_REGS = 7,
  localparam int unsigned DW      = TK_BYTE_W,
  localparam int unsigned NUM     = CLK_REGS + 1,
  localparam int unsigned PW      = $clog2(NUM),
  localparam int unsigned TW      = CLK_REGS * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          pwr_fail_i,
  input  logic          live_valid_i,
  output logic          live_ready_o,
  input  logic [TW-1:0] live_time_i,
  output logic [TW-1:0] time_o,
  output logic [DW-1:0] cal_o,
  output logic          div_rst_o
);
  localparam logic [PW-1:0] CLK_LIM = PW'(CLK_REGS);

  logic [1:0]    pads_s;
  logic          scl_rise, scl_fall, start_c, stop_c;
  logic [PW-1:0] ptr;
  logic          in_xfer, wr_stb;
  logic [DW-1:0] wr_data, rd_byte;

  tk_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(pads_s)
  );

  tk_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(pads_s[1]), .sda_s(pads_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c)
  );

  tk_bus_fsm #(.DEV_ADDR(DEV_ADDR), .CLK_REGS(CLK_REGS), .PW(PW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pf(pwr_fail_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c),
    .sda_in(pads_s[0]), .rd_byte(rd_byte), .sda_oe(sda_oe_o),
    .ptr_o(ptr), .in_xfer_o(in_xfer), .wr_stb_o(wr_stb), .wr_data_o(wr_data),
    .div_rst_o(div_rst_o)
  );

  // freeze the snapshot stream while the host sits on a clock index
  assign live_ready_o = !(in_xfer && ptr < CLK_LIM);

  tk_regfile #(.CLK_REGS(CLK_REGS), .PW(PW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_stb), .wr_addr(ptr), .wr_data(wr_data),
    .cp_en(live_valid_i && live_ready_o), .cp_data(live_time_i),
    .rd_addr(ptr), .rd_data(rd_byte), .time_o(time_o), .cal_o(cal_o)
  );
endmodule

// File: rtl/tk_i2c_regs_chk.sv
module tk_i2c_regs_chk #(
  parameter int unsigned PW       = 3,
  parameter int unsigned TW       = 56,
  parameter int unsigned CLK_REGS = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_fail,
  input logic          sda_oe,
  input logic [PW-1:0] ptr,
  input logic          wr_stb,
  input logic          div_rst,
  input logic          live_ready,
  input logic [TW-1:0] time_q,
  input logic [7:0]    cal_q
);
  p_pf_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> !sda_oe);

  p_pf_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (ptr == '0));

  p_div_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    div_rst |=> !div_rst);

  p_frozen_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!live_ready && !wr_stb) |=> $stable(time_q));

  p_cal_host_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && ptr == PW'(CLK_REGS)) |=> $stable(cal_q));
endmodule

bind tk_i2c_regs tk_i2c_regs_chk #(.PW(PW), .TW(TW), .CLK_REGS(CLK_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail_i), .sda_oe(sda_oe_o),
  .ptr(ptr), .wr_stb(wr_stb), .div_rst(div_rst_o), .live_ready(live_ready_o),
  .time_q(time_o), .cal_q(cal_o)
);

// File: tb/tk_i2c_regs_bench.sv
module tk_i2c_regs_bench;
  localparam int H = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic        pf = 1'b0;
  logic        lv = 1'b0;
  logic [55:0] lt = '0;
  logic        sda_oe, lr, div_rst;
  logic [55:0] time_q;
  logic [7:0]  cal_q;
  logic        sda_line;

  int n_chk = 0, n_err = 0, div_cnt = 0;
  logic [7:0] m [8];
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] rd_val;
  event       rd_ev;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  tk_i2c_regs u_tk_i2c_regs (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .pwr_fail_i(pf), .live_valid_i(lv), .live_ready_o(lr), .live_time_i(lt),
    .time_o(time_q), .cal_o(cal_q), .div_rst_o(div_rst)
  );

  always @(posedge clk) if (rst_n && div_rst) div_cnt++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [55:0] model_time();
    logic [55:0] r;
    for (int k = 0; k < 7; k++) r[8*k +: 8] = m[k];
    return r;
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0;
    end
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H/2); ack = sda_line; wt(H/2); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic nack);
    logic [7:0] v;
    v = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wt(H); scl_m = 1'b1; wt(H/2); v = {v[6:0], sda_line}; wt(H/2); scl_m = 1'b0;
    end
    wt(2); sda_m = nack; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(H/2); sda_m = 1'b1;
    rd_val = v;
    -> rd_ev;
  endtask

  task automatic expect_rd(input logic [7:0] v, input string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  // scoreboard monitor: pops the expected byte for every byte read back
  initial forever begin
    @(rd_ev);
    n_chk++;
    if (exp_q.size() == 0) begin
      n_err++;
      $display("FAIL read: actual=%h expected=<none>", rd_val);
    end else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (rd_val !== e) begin
        n_err++;
        $display("FAIL %s: actual=%h expected=%h", t, rd_val, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic a;
    for (int k = 0; k < 8; k++) m[k] = 8'h00;
    wt(5); rst_n = 1'b1; wt(5);

    // R10: reset state
    chk("R10", sda_oe, 0);
    chk("R10", lr, 1);
    chk("R10", time_q, 0);
    chk("R10", cal_q, 0);

    // R2: pointer write then two data bytes
    bus_start();
    send_byte(8'hD0, a); chk("R1", a, 0);
    send_byte(8'h02, a); chk("R2", a, 0);
    send_byte(8'h11, a); chk("R2", a, 0);
    send_byte(8'h22, a);
    bus_stop(); wt(4);
    m[2] = 8'h11; m[3] = 8'h22;
    chk("R2", time_q, model_time());
    chk("R7", div_cnt, 2);

    // R1: foreign address not acknowledged, rest ignored
    bus_start();
    send_byte(8'hA0, a); chk("R1", a, 1);
    send_byte(8'h00, a); chk("R1", a, 1);
    send_byte(8'h77, a);
    bus_stop(); wt(4);
    chk("R1", time_q, model_time());

    // R3: random read through repeated START
    bus_start();
    send_byte(8'hD0, a); send_byte(8'h02, a);
    bus_start();
    send_byte(8'hD1, a); chk("R1", a, 0);
    expect_rd(8'h11, "R3"); recv_byte(1'b0);
    expect_rd(8'h22, "R3"); recv_byte(1'b1);
    wt(4); chk("R4", sda_oe, 0);
    bus_stop();

    // R4: current-address read; NACK left pointer at 3
    bus_start();
    send_byte(8'hD1, a);
    expect_rd(8'h22, "R4"); recv_byte(1'b1);
    bus_stop();

    // R5/R6/R7: write wraps from 7 to 0
    bus_start();
    send_byte(8'hD0, a); send_byte(8'h07, a);
    send_byte(8'h5A, a); send_byte(8'h33, a);
    bus_stop(); wt(4);
    m[7] = 8'h5A; m[0] = 8'h33;
    chk("R6", cal_q, 8'h5A);
    chk("R5", time_q, model_time());
    chk("R7", div_cnt, 3);

    // R5: read wraps as well
    bus_start();
    send_byte(8'hD0, a); send_byte(8'h07, a);
    bus_start(); send_byte(8'hD1, a);
    expect_rd(8'h5A, "R5"); recv_byte(1'b0);
    expect_rd(8'h33, "R5"); recv_byte(1'b1);
    bus_stop();

    // R8: snapshot frozen while pointer on a clock index
    bus_start();
    send_byte(8'hD0, a); send_byte(8'h01, a);
    wt(4); chk("R8", lr, 0);
    lt = 56'h66_55_44_23_22_21_20; lv = 1'b1;
    wt(10); chk("R8", time_q, model_time());
    bus_stop(); wt(4);
    chk("R8", lr, 1);
    for (int k = 0; k < 7; k++) m[k] = lt[8*k +: 8];
    chk("R8", time_q, model_time());
    chk("R6", cal_q, 8'h5A);
    lv = 1'b0;

    // R8: ready returns when the pointer reaches 7 mid-transfer
    bus_start();
    send_byte(8'hD0, a); send_byte(8'h06, a); send_byte(8'h44, a);
    wt(4); chk("R8", lr, 1);
    bus_stop(); wt(4);
    m[6] = 8'h44;
    chk("R7", div_cnt, 4);

    // R9: power fail during a read while a 0 bit is on the line
    bus_start();
    send_byte(8'hD0, a); send_byte(8'h03, a);
    bus_start(); send_byte(8'hD1, a);
    wt(6); chk("R3", sda_oe, 1);
    pf = 1'b1; wt(3);
    chk("R9", sda_oe, 0);
    bus_stop();
    bus_start();
    send_byte(8'hD0, a); chk("R9", a, 1);
    send_byte(8'h04, a); send_byte(8'hEE, a);
    bus_stop(); wt(4);
    pf = 1'b0; wt(4);
    chk("R9", time_q, model_time());
    chk("R9", div_cnt, 4);
    bus_start();
    send_byte(8'hD1, a);
    expect_rd(m[0], "R9"); recv_byte(1'b1);
    bus_stop(); wt(10);

    chk("R3", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule